// File: doc/BRIEF.md
# Pin-Level I/O Connectivity Test Controller

This block sits between a chip's core logic and its digital pads and gives a board tester a static way to prove that every pin is soldered and routed. A dedicated test enable, a test data input and a test result output are added. The three functional mode-select pins are reused to choose the test while the enable is high.

In input-test mode the levels of all digital input pads are folded through an XOR chain, and the parity appears on the test output. Toggling any single pad on the board then toggles that output. In force mode every output driver is enabled and driven to the level on the test data input. In the high-impedance mode every output enable is released.

No test mode takes effect until a clear sequence has run since the last master reset. The sequence is one clock edge with the clear request high while the test enable is low. Once the mode is active, every result is a purely combinational function of pad levels. Outside test modes the core's values and enables pass straight through, and the core is modelled as a pass-through.

Top module: `pin_conn_test`

## Requirements
- R1: While `rst_n` is low, and after it until the first clear, `init_done` is 0. In that state outputs carry the core values and enables and `tst_dout` is 0, whatever `tst_en` and `mode_sel` are.
- R2: `init_done` becomes 1 at the first rising clock edge where `init_clr` is 1 and `tst_en` is 0. A clear request made while `tst_en` is 1 does not set it.
- R3: With `tst_en`=1, `init_done`=1 and `mode_sel`=3'b101 (`mode_sel[0]`=1, `mode_sel[1]`=0, `mode_sel[2]`=1), `tst_dout` equals the XOR of all bits of `pin_in`. It follows changes to `pin_in` without a clock edge.
- R4: With `tst_en`=1, `init_done`=1 and `mode_sel`=3'b011, every `pad_out` bit equals `tst_din` and every `pad_oe` bit is 1.
- R5: With `tst_en`=1, `init_done`=1 and `mode_sel`=3'b110, every `pad_oe` bit is 0, `pad_out` carries `core_out`, and `tst_dout` is 0.
- R6: With `tst_en`=1 and `init_done`=1, any `mode_sel` code other than 3'b101, 3'b011 and 3'b110 leaves every `pad_oe` bit at 0 and `tst_dout` at 0.
- R7: With `tst_en`=0, `pad_out`=`core_out`, `pad_oe`=`core_oe` and `tst_dout`=0 for every `mode_sel` code.
- R8: `core_in` always equals `pin_in`.
- R9: In input-test mode, `pad_out` and `pad_oe` carry `core_out` and `core_oe`.
- R10: Once set, `init_done` stays 1 through further clear requests and enable changes, and returns to 0 only on `rst_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the clear-sequence flag |
| rst_n | input | 1 | Master reset, active low |
| tst_en | input | 1 | Test structure enable |
| tst_din | input | 1 | Test data level for forced outputs |
| tst_dout | output | 1 | Input-chain parity result |
| init_clr | input | 1 | Clear-sequence request |
| init_done | output | 1 | Clear sequence completed since reset |
| mode_sel | input | 3 | Shared functional mode pins, test code selector |
| pin_in | input | N_IN | Digital input pad levels |
| core_in | output | N_IN | Input levels passed to the core |
| core_out | input | N_OUT | Core output values |
| core_oe | input | N_OUT | Core output enables |
| pad_out | output | N_OUT | Values to output pads |
| pad_oe | output | N_OUT | Output pad enables |

## Verification
The bench flips each input pad on its own from several base patterns. A chain with a dropped or duplicated tap would then leave the parity unchanged for that pad. It drives both test data levels under varied core values, so a force path stuck at one level or leaking core data shows up. Every undefined code is swept with the enable high, which catches a decoder that falls back to functional drive instead of releasing the pads. The clear sequence is attempted with the enable high and then repeated after it has completed, so the bench can tell whether the flag gates the modes, sets wrongly, or clears without a master reset.

// File: rtl/pct_pkg.sv
package pct_pkg;
   typedef enum logic [1:0] {
      MODE_FUNC  = 2'd0,
      MODE_IN    = 2'd1,
      MODE_FORCE = 2'd2,
      MODE_HIZ   = 2'd3
   } pct_mode_t;
endpackage

// File: rtl/pct_init_seq.sv
module pct_init_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic tst_en,
   input  logic init_clr,
   output logic init_done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         init_done <= 1'b0;
      else if (init_clr && !tst_en)
         init_done <= 1'b1;
   end

   // R2: clear request with enable low completes the sequence
   p_clr_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (init_clr && !tst_en) |=> init_done);
   // R10: flag only leaves 1 through master reset
   p_flag_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);
   // R2: enable high blocks a first-time set
   p_en_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_done && tst_en) |=> !init_done);
endmodule

// File: rtl/pct_mode_dec.sv
module pct_mode_dec
   import pct_pkg::*;
#(
   parameter int unsigned SEL_W      = 3,
   parameter logic [SEL_W-1:0] IN_CODE    = 3'b101,
   parameter logic [SEL_W-1:0] FORCE_CODE = 3'b011,
   parameter logic [SEL_W-1:0] HIZ_CODE   = 3'b110
) (
   input  logic             tst_en,
   input  logic             init_done,
   input  logic [SEL_W-1:0] mode_sel,
   output pct_mode_t        mode
);
   generate
      if (IN_CODE == FORCE_CODE || IN_CODE == HIZ_CODE || FORCE_CODE == HIZ_CODE) begin : g_bad_codes
         $error("pct_mode_dec: test mode codes must be distinct");
      end
   endgenerate

   always_comb begin
      if (!tst_en || !init_done)
         mode = MODE_FUNC;
      else if (mode_sel == IN_CODE)
         mode = MODE_IN;
      else if (mode_sel == FORCE_CODE)
         mode = MODE_FORCE;
      else
         mode = MODE_HIZ;   // named high-Z code and every undefined code
   end
endmodule

// File: rtl/pct_xor_chain.sv
module pct_xor_chain #(
   parameter int unsigned N_IN         = 8,
   parameter bit          LINEAR_CHAIN = 1'b1
) (
   input  logic [N_IN-1:0] bits_in,
   output logic            parity
);
   generate
      if (N_IN < 1) begin : g_bad_width
         $error("pct_xor_chain: N_IN must be at least 1");
      end
      if (LINEAR_CHAIN) begin : g_linear
         logic [N_IN-1:0] link;
         assign link[0] = bits_in[0];
         for (genvar i = 1; i < N_IN; i++) begin : g_tap
            assign link[i] = link[i-1] ^ bits_in[i];
         end
         assign parity = link[N_IN-1];
      end else begin : g_tree
         assign parity = ^bits_in;
      end
   endgenerate
endmodule

// File: rtl/pct_drv_mux.sv
module pct_drv_mux
   import pct_pkg::*;
#(
   parameter int unsigned N_OUT = 6
) (
   input  pct_mode_t        mode,
   input  logic             tst_din,
   input  logic [N_OUT-1:0] core_out,
   input  logic [N_OUT-1:0] core_oe,
   output logic [N_OUT-1:0] pad_out,
   output logic [N_OUT-1:0] pad_oe
);
   generate
      if (N_OUT < 1) begin : g_bad_width
         $error("pct_drv_mux: N_OUT must be at least 1");
      end
      for (genvar i = 0; i < N_OUT; i++) begin : g_pad
         always_comb begin
            unique case (mode)
               MODE_FORCE: begin
                  pad_out[i] = tst_din;
                  pad_oe[i]  = 1'b1;
               end
               MODE_HIZ: begin
                  pad_out[i] = core_out[i];
                  pad_oe[i]  = 1'b0;
               end
               default: begin
                  pad_out[i] = core_out[i];
                  pad_oe[i]  = core_oe[i];
               end
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/pin_conn_test.sv
module pin_conn_test
   import pct_pkg::*;
#(
   parameter int unsigned N_IN         = 8,
   parameter int unsigned N_OUT        = 6,
   parameter bit          LINEAR_CHAIN = 1'b1,
   parameter logic [2:0]  IN_CODE      = 3'b101,
   parameter logic [2:0]  FORCE_CODE   = 3'b011,
   parameter logic [2:0]  HIZ_CODE     = 3'b110
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tst_en,
   input  logic             tst_din,
   output logic             tst_dout,
   input  logic             init_clr,
   output logic             init_done,
   input  logic [2:0]       mode_sel,
   input  logic [N_IN-1:0]  pin_in,
   output logic [N_IN-1:0]  core_in,
   input  logic [N_OUT-1:0] core_out,
   input  logic [N_OUT-1:0] core_oe,
   output logic [N_OUT-1:0] pad_out,
   output logic [N_OUT-1:0] pad_oe
);
   pct_mode_t mode;
   logic      chain_par;

   pct_init_seq u_init (
      .clk       (clk),
      .rst_n     (rst_n),
      .tst_en    (tst_en),
      .init_clr  (init_clr),
      .init_done (init_done)
   );

   pct_mode_dec #(
      .SEL_W      (3),
      .IN_CODE    (IN_CODE),
      .FORCE_CODE (FORCE_CODE),
      .HIZ_CODE   (HIZ_CODE)
   ) u_dec (
      .tst_en    (tst_en),
      .init_done (init_done),
      .mode_sel  (mode_sel),
      .mode      (mode)
   );

   pct_xor_chain #(
      .N_IN         (N_IN),
      .LINEAR_CHAIN (LINEAR_CHAIN)
   ) u_chain (
      .bits_in (pin_in),
      .parity  (chain_par)
   );

   pct_drv_mux #(
      .N_OUT (N_OUT)
   ) u_mux (
      .mode     (mode),
      .tst_din  (tst_din),
      .core_out (core_out),
      .core_oe  (core_oe),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe)
   );

   assign core_in  = pin_in;
   assign tst_dout = (mode == MODE_IN) ? chain_par : 1'b0;

   // R1: before the clear sequence nothing reaches the pads
   p_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |-> (pad_out == core_out && pad_oe == core_oe && !tst_dout));
   // R3: chain result seen on the test output
   p_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tst_en && init_done && mode_sel == IN_CODE) |-> (tst_dout == ^pin_in));
   // R4: every driver follows the test data level
   p_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tst_en && init_done && mode_sel == FORCE_CODE)
         |-> (pad_out == {N_OUT{tst_din}} && pad_oe == {N_OUT{1'b1}}));
   // R5: named high-Z code releases all drivers
   p_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tst_en && init_done && mode_sel == HIZ_CODE) |-> (pad_oe == '0 && !tst_dout));
   // R6: undefined codes fall to released drivers
   p_undef_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tst_en && init_done && mode_sel != IN_CODE && mode_sel != FORCE_CODE
         && mode_sel != HIZ_CODE) |-> (pad_oe == '0 && !tst_dout));
   // R7: enable low means functional pass-through
   p_func_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !tst_en |-> (pad_out == core_out && pad_oe == core_oe && !tst_dout));
   // R9: input test leaves the output pads functional
   p_in_pads_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tst_en && init_done && mode_sel == IN_CODE) |-> (pad_oe == core_oe));
endmodule

// File: tb/pin_conn_test_bench.sv
module pin_conn_test_bench;
   localparam int NI = 8;
   localparam int NO = 6;

   typedef struct packed {
      logic [7:0]    req;
      logic [NO-1:0] e_out;
      logic [NO-1:0] e_oe;
      logic          e_dout;
      logic          e_init;
      logic [NI-1:0] e_cin;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tst_en = 1'b0, tst_din = 1'b0, init_clr = 1'b0;
   logic [2:0] mode_sel = 3'b000;
   logic [NI-1:0] pin_in = '0;
   logic [NO-1:0] core_out = '0, core_oe = '0;
   logic tst_dout, init_done;
   logic [NI-1:0] core_in;
   logic [NO-1:0] pad_out, pad_oe;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic exp_init = 1'b0;
   exp_t sb_q[$];
   event chk_ev;

   always #4 clk = ~clk;   // 125 MHz

   pin_conn_test u_pin_conn_test (
      .clk(clk), .rst_n(rst_n), .tst_en(tst_en), .tst_din(tst_din),
      .tst_dout(tst_dout), .init_clr(init_clr), .init_done(init_done),
      .mode_sel(mode_sel), .pin_in(pin_in), .core_in(core_in),
      .core_out(core_out), .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   function automatic exp_t model(int req);
      exp_t e;
      logic act;
      act = tst_en && exp_init;
      e.req   = 8'(req);
      e.e_cin = pin_in;
      e.e_init = exp_init;
      e.e_dout = (act && mode_sel == 3'b101) ? ^pin_in : 1'b0;
      if (act && mode_sel == 3'b011) begin
         e.e_out = {NO{tst_din}};
         e.e_oe  = '1;
      end else if (act && mode_sel != 3'b101) begin
         e.e_out = core_out;
         e.e_oe  = '0;
      end else begin
         e.e_out = core_out;
         e.e_oe  = core_oe;
      end
      return e;
   endfunction

   // driver: apply stimulus away from the edge, push expectation
   task automatic drive(int req, logic en, logic [2:0] sel, logic din,
                        logic [NI-1:0] pins, logic [NO-1:0] co, logic [NO-1:0] coe);
      @(negedge clk);
      tst_en = en; mode_sel = sel; tst_din = din;
      pin_in = pins; core_out = co; core_oe = coe;
      sb_q.push_back(model(req));
      -> chk_ev;
      #2;
   endtask

   task automatic clr_pulse(logic en);
      @(negedge clk);
      init_clr = 1'b1; tst_en = en;
      @(posedge clk);
      if (!en) exp_init = 1'b1;   // R2 / R10 expectation
      @(negedge clk);
      init_clr = 1'b0;
   endtask

   // monitor: pop and compare
   initial begin
      forever begin
         exp_t e;
         @(chk_ev);
         #1;
         e = sb_q.pop_front();
         checks++;
         if (pad_out !== e.e_out || pad_oe !== e.e_oe || tst_dout !== e.e_dout ||
             init_done !== e.e_init || core_in !== e.e_cin) begin
            errors++;
            $display("FAIL R%0d: out=%b oe=%b dout=%b init=%b cin=%b exp out=%b oe=%b dout=%b init=%b cin=%b",
                     e.req, pad_out, pad_oe, tst_dout, init_done, core_in,
                     e.e_out, e.e_oe, e.e_dout, e.e_init, e.e_cin);
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset held, test request must not act
      drive(1, 1'b1, 3'b101, 1'b1, 8'hA5, 6'h2B, 6'h15);
      drive(1, 1'b1, 3'b011, 1'b1, 8'h01, 6'h00, 6'h3F);
      @(negedge clk); rst_n = 1'b1;
      // R1: out of reset but no clear yet
      drive(1, 1'b1, 3'b011, 1'b1, 8'h3C, 6'h12, 6'h21);
      drive(1, 1'b1, 3'b110, 1'b0, 8'h7F, 6'h33, 6'h3F);
      // R2: clear with enable high is refused
      clr_pulse(1'b1);
      drive(2, 1'b1, 3'b101, 1'b0, 8'h80, 6'h0F, 6'h0F);
      // R2: clear with enable low completes
      clr_pulse(1'b0);
      drive(2, 1'b0, 3'b000, 1'b0, 8'h11, 6'h05, 6'h3A);
      // R7: enable low across all codes; R8 in every item
      for (int c = 0; c < 8; c++)
         drive(7, 1'b0, 3'(c), 1'(c), 8'(c * 37 + 5), 6'(c * 11), 6'(c * 7 + 1));
      // R3 / R9: single-bit flips from several bases
      for (int b = 0; b < 3; b++) begin
         logic [NI-1:0] base;
         base = (b == 0) ? 8'h00 : (b == 1) ? 8'hFF : 8'h96;
         drive(3, 1'b1, 3'b101, 1'b0, base, 6'h2A, 6'h1C);
         for (int k = 0; k < NI; k++)
            drive(3, 1'b1, 3'b101, 1'b1, base ^ (8'h01 << k), 6'h15, 6'h23);
      end
      drive(9, 1'b1, 3'b101, 1'b1, 8'h40, 6'h3E, 6'h01);
      // R4: force both levels, varied core data
      drive(4, 1'b1, 3'b011, 1'b1, 8'h00, 6'h00, 6'h00);
      drive(4, 1'b1, 3'b011, 1'b0, 8'hFF, 6'h3F, 6'h00);
      drive(4, 1'b1, 3'b011, 1'b1, 8'h55, 6'h2A, 6'h15);
      drive(4, 1'b1, 3'b011, 1'b0, 8'hAA, 6'h15, 6'h3F);
      // R5: high-Z code
      drive(5, 1'b1, 3'b110, 1'b1, 8'h01, 6'h3F, 6'h3F);
      drive(5, 1'b1, 3'b110, 1'b0, 8'hFE, 6'h09, 6'h36);
      // R6: every undefined code
      for (int c = 0; c < 8; c++)
         if (c != 5 && c != 3 && c != 6)
            drive(6, 1'b1, 3'(c), 1'b1, 8'(c * 29 + 1), 6'(c * 5 + 2), 6'h3F);
      // R10: further clears and enable toggles keep the flag
      clr_pulse(1'b1);
      clr_pulse(1'b0);
      drive(10, 1'b0, 3'b101, 1'b0, 8'h0F, 6'h07, 6'h38);
      drive(10, 1'b1, 3'b011, 1'b1, 8'hF0, 6'h00, 6'h00);
      // R10 / R1: master reset drops it again
      @(negedge clk); rst_n = 1'b0; exp_init = 1'b0;
      drive(10, 1'b1, 3'b011, 1'b1, 8'h33, 6'h19, 6'h26);
      @(negedge clk); rst_n = 1'b1;
      drive(1, 1'b1, 3'b101, 1'b0, 8'h01, 6'h24, 6'h1B);
      #20;
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule